// File: doc/BRIEF.md
# Frame-Boundary Shadow Register Bank

This block is the configuration store of a two-window display controller. Software writes land in a shadow copy of each window's settings (an enable bit, a pixel format code and a buffer base address). The copy that drives scan-out, the active copy, is loaded from the shadow copy only on a cycle where the frame-boundary strobe `vsync` is high. A half-finished set of writes therefore never reaches the scan-out logic in the middle of a frame.

Each window has its own hold bit. While a window's hold bit is set, a frame boundary passes over that window and leaves its active settings as they were, while the other window may still be loaded. The transfer only happens when it is armed. Any write to a window's shadow registers arms it, and so does writing 1 to the request register or clearing a hold bit. The arm flag clears itself at the next frame boundary. Reads return shadow values. A status register shows the active enable bits.

Register map (word addresses): 0 = hold bits (bit w holds window w, takes effect at once); 1 = transfer request (write 1 to bit 0 to arm; a read gives the arm flag in bit 0); 2 = active enable status (read-only, bit w = window w); 4+2w = window w control (bit 0 enable, bits 3:1 format); 5+2w = window w base address. Every other address reads 0 and ignores writes.

Top module: `vsync_shadow_bank`

## Requirements
- R1: After reset, every shadow and active field is zero, all hold bits are 0, the arm flag is 0, and all windows are disabled.
- R2: A write to a window's control (4+2w) or base (5+2w) register can be read back on the next cycle. The active outputs do not change until a frame boundary.
- R3: On a cycle with `vsync` high and the arm flag set, every window whose hold bit is 0 has its active enable, format and base loaded from its shadow copy. The new values are visible after that clock edge.
- R4: A window whose hold bit (address 0, bit w) is 1 keeps its active values across an armed frame boundary. The other window is still loaded.
- R5: A write to address 0 that clears a hold bit that was set arms the transfer. The window's pending values are loaded at the next frame boundary.
- R6: Writing 1 to bit 0 of address 1 arms the transfer, and address 1 then reads 1. Any write to a window register also arms it. The arm flag returns to 0 after a frame boundary that has no arming write in the same cycle.
- R7: Clearing a window's enable bit in its control register leaves that window's active enable, and its bit in status (address 2), set until the next armed frame boundary.
- R8: Writes to the status register (address 2) are ignored. Status and the arm flag are unchanged.
- R9: If a shadow write and `vsync` fall in the same cycle, the transfer uses the shadow values from before the write, and the write arms the next frame boundary.
- R10: If a hold-bit write and `vsync` fall in the same cycle, the transfer uses the hold bits from before the write.
- R11: Unmapped addresses (3 and 8..15) read as 0. Writes to them change no state and do not arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address, used for both reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| vsync | input | 1 | One-cycle frame-boundary strobe |
| act_en | output | NUM_WIN | Active enable per window |
| act_fmt | output | NUM_WIN*FMT_W | Active format codes, window w at [w*FMT_W +: FMT_W] |
| act_base | output | NUM_WIN*DATA_W | Active base addresses, window w at [w*DATA_W +: DATA_W] |

## Verification
Read data is combinational. A value written at one clock edge can be read just after that edge. Active outputs, status and the arm flag change at the edge where `vsync` is sampled high and are visible just after it. The bench drives its inputs two time units after a rising edge, makes directed reads one unit later, and compares every output against a behavioural model on each falling edge. Each result is therefore checked in the cycle it is due and never sooner. The same-cycle cases (R9, R10) are checked right after the shared edge, so the old-value rules are seen directly.

// File: rtl/vsbank_pkg.sv
package vsbank_pkg;

    localparam logic [7:0] ADR_HOLD = 8'h00;
    localparam logic [7:0] ADR_REQ  = 8'h01;
    localparam logic [7:0] ADR_STAT = 8'h02;
    localparam logic [7:0] ADR_WIN0 = 8'h04;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_HOLD,
        RK_REQ,
        RK_STAT,
        RK_CTRL,
        RK_BASE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] win;
    } reg_sel_t;

    // win_end is the first address past the last window register
    function automatic reg_sel_t decode_addr(input logic [7:0] a, input logic [7:0] win_end);
        reg_sel_t   s;
        logic [7:0] off;
        s.kind = RK_NONE;
        s.win  = '0;
        off    = a - ADR_WIN0;
        if (a == ADR_HOLD)      s.kind = RK_HOLD;
        else if (a == ADR_REQ)  s.kind = RK_REQ;
        else if (a == ADR_STAT) s.kind = RK_STAT;
        else if (a >= ADR_WIN0 && a < win_end) begin
            s.kind = a[0] ? RK_BASE : RK_CTRL;
            s.win  = off[4:1];
        end
        return s;
    endfunction

endpackage

// File: rtl/vsbank_ctl.sv
module vsbank_ctl #(
    parameter int NUM_WIN = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vsync,
    input  logic               wr_hold,
    input  logic               wr_req,
    input  logic               wr_shadow,
    input  logic [NUM_WIN-1:0] hold_wdata,
    input  logic               req_bit,
    output logic [NUM_WIN-1:0] hold_q,
    output logic               arm_q,
    output logic [NUM_WIN-1:0] load
);

    logic arm_set;

    assign arm_set = wr_shadow
                   | (wr_req & req_bit)
                   | (wr_hold & (|(hold_q & ~hold_wdata)));

    assign load = {NUM_WIN{vsync & arm_q}} & ~hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            arm_q  <= 1'b0;
        end else begin
            if (wr_hold) hold_q <= hold_wdata;
            if (arm_set)    arm_q <= 1'b1;
            else if (vsync) arm_q <= 1'b0;
        end
    end

    // R5: releasing a held window arms the next transfer
    p_release_arms_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_hold && |(hold_q & ~hold_wdata)) |=> arm_q);

    // R6: arm flag clears at a frame boundary with no arming write
    p_arm_selfclear_r6: assert property (@(posedge clk) disable iff (rst)
        (vsync && !wr_hold && !wr_req && !wr_shadow) |=> !arm_q);

endmodule

// File: rtl/vsbank_win.sv
module vsbank_win #(
    parameter int DATA_W = 16,
    parameter int FMT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_base,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output logic              shd_en,
    output logic [FMT_W-1:0]  shd_fmt,
    output logic [DATA_W-1:0] shd_base,
    output logic              act_en,
    output logic [FMT_W-1:0]  act_fmt,
    output logic [DATA_W-1:0] act_base
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_en   <= 1'b0;
            shd_fmt  <= '0;
            shd_base <= '0;
            act_en   <= 1'b0;
            act_fmt  <= '0;
            act_base <= '0;
        end else begin
            // load copies the pre-write shadow value (R9)
            if (load) begin
                act_en   <= shd_en;
                act_fmt  <= shd_fmt;
                act_base <= shd_base;
            end
            if (wr_ctrl) begin
                shd_en  <= wdata[0];
                shd_fmt <= wdata[FMT_W:1];
            end
            if (wr_base) shd_base <= wdata;
        end
    end

    // R2: active copy is quiet unless a load happens
    p_active_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(act_en) && $stable(act_fmt) && $stable(act_base)));

    // R3: a load takes the shadow contents of that cycle
    p_load_copies_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (act_en == $past(shd_en) && act_fmt == $past(shd_fmt)
                  && act_base == $past(shd_base)));

endmodule

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank
    import vsbank_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int DATA_W  = 16,
    parameter int FMT_W   = 3,
    parameter int ADDR_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    input  logic                      vsync,
    output logic [NUM_WIN-1:0]        act_en,
    output logic [NUM_WIN*FMT_W-1:0]  act_fmt,
    output logic [NUM_WIN*DATA_W-1:0] act_base
);

    localparam logic [7:0] WIN_END = 8'(4 + 2 * NUM_WIN);
    localparam int         WIN_IW  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    reg_sel_t           sel;
    logic [NUM_WIN-1:0] hold_q;
    logic [NUM_WIN-1:0] load;
    logic [NUM_WIN-1:0] wr_ctrl;
    logic [NUM_WIN-1:0] wr_base;
    logic               arm_q;
    logic               wr_shadow;

    logic               shd_en   [NUM_WIN];
    logic [FMT_W-1:0]   shd_fmt  [NUM_WIN];
    logic [DATA_W-1:0]  shd_base [NUM_WIN];

    assign sel       = decode_addr(8'(addr), WIN_END);
    assign wr_shadow = |(wr_ctrl | wr_base);

    vsbank_ctl #(.NUM_WIN(NUM_WIN)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .vsync      (vsync),
        .wr_hold    (wr_en && sel.kind == RK_HOLD),
        .wr_req     (wr_en && sel.kind == RK_REQ),
        .wr_shadow  (wr_shadow),
        .hold_wdata (wdata[NUM_WIN-1:0]),
        .req_bit    (wdata[0]),
        .hold_q     (hold_q),
        .arm_q      (arm_q),
        .load       (load)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign wr_ctrl[w] = wr_en && sel.kind == RK_CTRL && sel.win == 4'(w);
        assign wr_base[w] = wr_en && sel.kind == RK_BASE && sel.win == 4'(w);

        vsbank_win #(.DATA_W(DATA_W), .FMT_W(FMT_W)) u_win (
            .clk      (clk),
            .rst      (rst),
            .wr_ctrl  (wr_ctrl[w]),
            .wr_base  (wr_base[w]),
            .wdata    (wdata),
            .load     (load[w]),
            .shd_en   (shd_en[w]),
            .shd_fmt  (shd_fmt[w]),
            .shd_base (shd_base[w]),
            .act_en   (act_en[w]),
            .act_fmt  (act_fmt[w*FMT_W +: FMT_W]),
            .act_base (act_base[w*DATA_W +: DATA_W])
        );

        // R4: a held window keeps its active values across the boundary
        p_hold_keeps_r4: assert property (@(posedge clk) disable iff (rst)
            (vsync && hold_q[w]) |=> ($stable(act_en[w])
                && $stable(act_base[w*DATA_W +: DATA_W])));
    end

    always_comb begin
        logic [WIN_IW-1:0] wi;
        wi    = sel.win[WIN_IW-1:0];
        rdata = '0;
        case (sel.kind)
            RK_HOLD: rdata[NUM_WIN-1:0] = hold_q;
            RK_REQ:  rdata[0]           = arm_q;
            RK_STAT: rdata[NUM_WIN-1:0] = act_en;
            RK_CTRL: rdata[FMT_W:0]     = {shd_fmt[wi], shd_en[wi]};
            RK_BASE: rdata              = shd_base[wi];
            default: rdata              = '0;
        endcase
    end

endmodule

// File: tb/sim_vsync_shadow_bank.sv
module sim_vsync_shadow_bank;

    localparam int CLK_P = 10;
    localparam int NW    = 2;
    localparam int DW    = 16;
    localparam int FW    = 3;
    localparam int AW    = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic            vsync = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic [NW-1:0]   act_en;
    logic [NW*FW-1:0] act_fmt;
    logic [NW*DW-1:0] act_base;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic          m_sen [NW];
    logic [FW-1:0] m_sfmt[NW];
    logic [DW-1:0] m_sbase[NW];
    logic          m_aen [NW];
    logic [FW-1:0] m_afmt[NW];
    logic [DW-1:0] m_abase[NW];
    logic [NW-1:0] m_hold;
    logic          m_arm;

    vsync_shadow_bank #(.NUM_WIN(NW), .DATA_W(DW), .FMT_W(FW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .vsync(vsync), .act_en(act_en), .act_fmt(act_fmt),
        .act_base(act_base)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        logic [NW-1:0] h_old;
        logic          arming;
        int            wi;
        if (rst) begin
            for (int w = 0; w < NW; w++) begin
                m_sen[w] = 0; m_sfmt[w] = 0; m_sbase[w] = 0;
                m_aen[w] = 0; m_afmt[w] = 0; m_abase[w] = 0;
            end
            m_hold = 0;
            m_arm  = 0;
        end else begin
            h_old  = m_hold;
            arming = 0;
            if (vsync && m_arm) begin
                for (int w = 0; w < NW; w++) begin
                    if (!h_old[w]) begin
                        m_aen[w] = m_sen[w]; m_afmt[w] = m_sfmt[w]; m_abase[w] = m_sbase[w];
                    end
                end
            end
            if (wr_en) begin
                if (addr == 0) begin
                    if ((h_old & ~wdata[NW-1:0]) != 0) arming = 1;
                    m_hold = wdata[NW-1:0];
                end else if (addr == 1) begin
                    if (wdata[0]) arming = 1;
                end else if (int'(addr) >= 4 && int'(addr) < 4 + 2*NW) begin
                    wi = (int'(addr) - 4) / 2;
                    if (addr[0]) m_sbase[wi] = wdata;
                    else begin m_sen[wi] = wdata[0]; m_sfmt[wi] = wdata[FW:1]; end
                    arming = 1;
                end
            end
            if (arming) m_arm = 1;
            else if (vsync) m_arm = 0;
        end
    end

    function automatic logic [DW-1:0] mrd(input logic [AW-1:0] a);
        logic [DW-1:0] r;
        int wi;
        r = '0;
        if (a == 0) r[NW-1:0] = m_hold;
        else if (a == 1) r[0] = m_arm;
        else if (a == 2) begin
            for (int w = 0; w < NW; w++) r[w] = m_aen[w];
        end else if (int'(a) >= 4 && int'(a) < 4 + 2*NW) begin
            wi = (int'(a) - 4) / 2;
            if (a[0]) r = m_sbase[wi];
            else r[FW:0] = {m_sfmt[wi], m_sen[wi]};
        end
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] actual, input logic [31:0] expected);
        vectors++;
        if (actual !== expected) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, actual, expected);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            for (int w = 0; w < NW; w++) begin
                check("R3", "active enable", 32'(act_en[w]), 32'(m_aen[w]));
                check("R3", "active format", 32'(act_fmt[w*FW +: FW]), 32'(m_afmt[w]));
                check("R3", "active base", 32'(act_base[w*DW +: DW]), 32'(m_abase[w]));
            end
            check("R2", "readback", 32'(rdata), 32'(mrd(addr)));
        end
    end

    task automatic step(input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic vs);
        wr_en = w; addr = a; wdata = d; vsync = vs;
        @(posedge clk);
        #2;
        wr_en = 0; vsync = 0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        step(1'b1, a, d, 1'b0);
    endtask

    task automatic vs();
        step(1'b0, addr, '0, 1'b1);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req, input logic [DW-1:0] exp);
        addr = a;
        #1;
        check(req, "register read", 32'(rdata), 32'(exp));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;

        // R1 reset state
        check("R1", "act_en", 32'(act_en), 0);
        check("R1", "act_base", act_base, 0);
        rd(4'd0, "R1", 16'h0);
        rd(4'd1, "R1", 16'h0);
        rd(4'd2, "R1", 16'h0);
        rd(4'd4, "R1", 16'h0);

        // R2 shadow write deferred
        wr(4'd4, 16'h000B);
        wr(4'd5, 16'h1234);
        rd(4'd4, "R2", 16'h000B);
        rd(4'd5, "R2", 16'h1234);
        check("R2", "act_en before boundary", 32'(act_en), 0);
        rd(4'd1, "R6", 16'h1);

        // R3 transfer
        vs();
        check("R3", "win0 enable", 32'(act_en[0]), 1);
        check("R3", "win0 format", 32'(act_fmt[2:0]), 5);
        check("R3", "win0 base", 32'(act_base[15:0]), 32'h1234);
        rd(4'd1, "R6", 16'h0);

        // R4 hold window 1
        wr(4'd0, 16'h0002);
        wr(4'd6, 16'h0003);
        wr(4'd7, 16'hBEEF);
        wr(4'd5, 16'h0055);
        vs();
        check("R4", "win0 loaded", 32'(act_base[15:0]), 32'h0055);
        check("R4", "win1 held enable", 32'(act_en[1]), 0);
        check("R4", "win1 held base", 32'(act_base[31:16]), 0);

        // R5 release arms
        vs();
        rd(4'd1, "R6", 16'h0);
        wr(4'd0, 16'h0000);
        rd(4'd1, "R5", 16'h1);
        vs();
        check("R5", "win1 enable", 32'(act_en[1]), 1);
        check("R5", "win1 base", 32'(act_base[31:16]), 32'hBEEF);

        // R6 request bit
        wr(4'd1, 16'h0000);
        rd(4'd1, "R6", 16'h0);
        wr(4'd1, 16'h0001);
        rd(4'd1, "R6", 16'h1);
        vs();
        rd(4'd1, "R6", 16'h0);

        // R7 enable clear deferred
        wr(4'd4, 16'h0000);
        rd(4'd2, "R7", 16'h3);
        vs();
        rd(4'd2, "R7", 16'h2);
        check("R7", "act_en", 32'(act_en), 2);

        // R8 status read-only
        wr(4'd2, 16'h0000);
        rd(4'd2, "R8", 16'h2);
        rd(4'd1, "R8", 16'h0);

        // R9 write and boundary together
        wr(4'd4, 16'h0001);
        step(1'b1, 4'd7, 16'h7777, 1'b1);
        check("R9", "win0 loaded", 32'(act_en[0]), 1);
        check("R9", "win1 old base", 32'(act_base[31:16]), 32'hBEEF);
        rd(4'd1, "R9", 16'h1);
        vs();
        check("R9", "win1 new base", 32'(act_base[31:16]), 32'h7777);

        // R10 hold write and boundary together
        wr(4'd5, 16'h0A0A);
        step(1'b1, 4'd0, 16'h0001, 1'b1);
        check("R10", "old hold used", 32'(act_base[15:0]), 32'h0A0A);
        wr(4'd5, 16'h0B0B);
        vs();
        check("R10", "now held", 32'(act_base[15:0]), 32'h0A0A);
        wr(4'd0, 16'h0000);
        vs();
        check("R10", "released", 32'(act_base[15:0]), 32'h0B0B);

        // R11 unmapped
        vs();
        wr(4'd15, 16'hFFFF);
        wr(4'd3, 16'hFFFF);
        rd(4'd15, "R11", 16'h0);
        rd(4'd3, "R11", 16'h0);
        rd(4'd1, "R11", 16'h0);
        rd(4'd0, "R11", 16'h0);

        repeat (2) @(posedge clk);
        #2;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!finished) begin
            finished = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule